// File: doc/BRIEF.md
# Repeater Port Auto-Partition Controller

This block isolates misbehaving ports of a multi-port Ethernet repeater and brings them back without software. Each port has its own controller. The controller watches two inputs from its port: activity, meaning the port is carrying or receiving a frame, and collision. A shared bit-time tick paces all ports. The controller counts collisions that follow one another with no clean frame between them. When that count reaches 64, it partitions the port.

A single collision that lasts too long also partitions the port at once. A partitioned port still reports its activity and collisions to its own controller. Its received data is not forwarded, because its forward-enable output is held low. The port reconnects by itself after it carries one collision-free frame longer than the duration window. That window is a parameter of 450 to 560 bit times, 500 by default, and it also sets how long a collision may last.

Each port runs a state machine of seven states. Three states track a connected port that is idle, active, or colliding. A fourth state (LINK_TAIL) holds a connected port whose collision has ended while its activity continues. Three isolated states wait for the line to go quiet (ISO_WAIT), sit idle (ISO_IDLE), or time a candidate reconnection frame (ISO_ACT).

The transitions are:
- LINK_IDLE→LINK_ACT on activity.
- LINK_IDLE, LINK_ACT or LINK_TAIL→LINK_COLL when a collision starts. This step counts the collision.
- Any of those three states→ISO_WAIT when the collision just counted is the 64th.
- LINK_ACT→LINK_IDLE when a clean frame ends. This step clears the count.
- LINK_COLL→LINK_TAIL when the collision ends while activity continues.
- LINK_COLL→LINK_IDLE when the collision and the activity both end.
- LINK_COLL→ISO_WAIT when the collision outlasts the window.
- LINK_TAIL→LINK_IDLE when the activity ends.
- ISO_WAIT→ISO_IDLE once the line is quiet.
- ISO_IDLE→ISO_WAIT on a collision.
- ISO_IDLE→ISO_ACT on activity.
- ISO_ACT→ISO_WAIT on a collision.
- ISO_ACT→ISO_IDLE when a short frame ends.
- ISO_ACT→LINK_IDLE when a frame longer than the window ends. This step reconnects the port and clears its count.

Top module: `port_partition_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every port. After reset, `port_part` is 0 and every count field is 0.
- R2: Port p's count is read from `coll_count[p*7 +: 7]`. In a connected state, each collision start (collision rising) adds 1 to that count at the next clock edge.
- R3: The collision that brings a port's count to 64 partitions the port. `port_part` goes high one cycle after that collision starts, the count reads 64, and the count never exceeds 64.
- R4: A frame that ends without any collision inside it clears the port's count to 0.
- R5: A frame that contains a collision does not clear the count. Collisions spread over separate frames keep adding up.
- R6: A collision that lasts more than the window (500 bit-time ticks by default) partitions the port. This does not change the count.
- R7: A collision shorter than the window leaves the port connected.
- R8: While a port is partitioned, its `port_fwd_en` stays 0 even with activity present, and its collisions do not change its count.
- R9: A partitioned port reconnects when a collision-free frame longer than the window ends, and its count clears to 0. A shorter frame leaves it partitioned.
- R10: The duration timer advances only on cycles where `bit_tick` is 1. A collision held with no ticks never partitions the port.
- R11: Ports are independent. Events on one port change no other port's flag or count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | One-cycle pulse per bit time, shared by all ports |
| port_coll | input | NUM_PORTS | Collision seen on each port |
| port_act | input | NUM_PORTS | Activity (frame) present on each port |
| port_part | output | NUM_PORTS | Port is partitioned |
| port_fwd_en | output | NUM_PORTS | Port's received data may be repeated to other ports |
| coll_count | output | NUM_PORTS*7 | Consecutive-collision count per port, 7 bits each, port 0 lowest |

## Verification
A wrong count shows up at the count field one cycle after the collision edge that caused it. It also decides whether the 64th collision raises the partition flag on the very next cycle, so an off-by-one in the limit is caught at that boundary. A state machine stuck in an isolated state shows up as a flag that stays high one cycle after a long clean frame ends, or as a forward enable that stays high during a partition. A timer that runs too fast or ignores the tick shows up as a flag that rises before 450 ticks, or that rises while the tick is held low.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
    typedef enum logic [2:0] {
        ST_LINK_IDLE,
        ST_LINK_ACT,
        ST_LINK_COLL,
        ST_LINK_TAIL,
        ST_ISO_WAIT,
        ST_ISO_IDLE,
        ST_ISO_ACT
    } port_state_e;
endpackage

// File: rtl/ppc_bit_timer.sv
module ppc_bit_timer #(
    parameter int TW_LEN = 500,
    localparam int TW_W  = $clog2(TW_LEN + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    input  logic bit_tick,
    output logic expired
);
    logic [TW_W-1:0] ticks;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ticks <= '0;
        end else if (run && bit_tick && (ticks != TW_W'(TW_LEN))) begin
            ticks <= ticks + 1'b1;
        end
    end

    assign expired = (ticks == TW_W'(TW_LEN));

    // R10: the timer saturates at the window and never wraps
    a_r10_timer_bound: assert property (@(posedge clk) disable iff (rst)
        ticks <= TW_W'(TW_LEN));

    // R10: the timer does not advance without a tick
    a_r10_tick_gate: assert property (@(posedge clk) disable iff (rst)
        (!bit_tick && !clr) |=> $stable(ticks));
endmodule

// File: rtl/ppc_coll_counter.sv
module ppc_coll_counter #(
    parameter int LIMIT = 64,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          clr,
    output logic [CW-1:0] count,
    output logic          at_last
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (inc && (count != CW'(LIMIT))) begin
            count <= count + 1'b1;
        end
    end

    assign at_last = (count == CW'(LIMIT - 1));

    // R3: the count saturates at the limit
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(LIMIT));

    // R2: one increment adds exactly one
    a_r2_step_one: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr && count != CW'(LIMIT)) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/ppc_port_fsm.sv
module ppc_port_fsm
    import ppc_pkg::*;
#(
    parameter int LIMIT  = 64,
    parameter int TW_LEN = 500,
    localparam int CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_tick,
    input  logic          coll,
    input  logic          act,
    output logic          part,
    output logic          fwd_en,
    output logic [CW-1:0] count
);
    port_state_e state, nxt;
    logic cnt_inc, cnt_clr, tmr_clr, tmr_run, expired, at_last;

    ppc_coll_counter #(.LIMIT(LIMIT)) u_cnt (
        .clk(clk), .rst(rst), .inc(cnt_inc), .clr(cnt_clr),
        .count(count), .at_last(at_last)
    );

    ppc_bit_timer #(.TW_LEN(TW_LEN)) u_tmr (
        .clk(clk), .rst(rst), .clr(tmr_clr), .run(tmr_run),
        .bit_tick(bit_tick), .expired(expired)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_LINK_IDLE;
        else     state <= nxt;
    end

    // next state and counter/timer controls
    always_comb begin
        nxt     = state;
        cnt_inc = 1'b0;
        cnt_clr = 1'b0;
        tmr_clr = 1'b0;
        unique case (state)
            ST_LINK_IDLE, ST_LINK_ACT, ST_LINK_TAIL: begin
                if (coll) begin
                    cnt_inc = 1'b1;
                    tmr_clr = 1'b1;
                    nxt     = at_last ? ST_ISO_WAIT : ST_LINK_COLL;
                end else if (state == ST_LINK_IDLE) begin
                    if (act) nxt = ST_LINK_ACT;
                end else if (!act) begin
                    nxt = ST_LINK_IDLE;
                    if (state == ST_LINK_ACT) cnt_clr = 1'b1;
                end
            end
            ST_LINK_COLL: begin
                if (coll) begin
                    if (expired) nxt = ST_ISO_WAIT;
                end else if (act) begin
                    nxt = ST_LINK_TAIL;
                end else begin
                    nxt = ST_LINK_IDLE;
                end
            end
            ST_ISO_WAIT: begin
                if (!coll && !act) nxt = ST_ISO_IDLE;
            end
            ST_ISO_IDLE: begin
                if (coll) begin
                    nxt = ST_ISO_WAIT;
                end else if (act) begin
                    nxt     = ST_ISO_ACT;
                    tmr_clr = 1'b1;
                end
            end
            ST_ISO_ACT: begin
                if (coll) begin
                    nxt = ST_ISO_WAIT;
                end else if (!act) begin
                    if (expired) begin
                        nxt     = ST_LINK_IDLE;
                        cnt_clr = 1'b1;
                    end else begin
                        nxt = ST_ISO_IDLE;
                    end
                end
            end
            default: nxt = ST_LINK_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        tmr_run = 1'b0;
        part    = 1'b0;
        unique case (state)
            ST_LINK_COLL: tmr_run = 1'b1;
            ST_ISO_ACT: begin
                tmr_run = 1'b1;
                part    = 1'b1;
            end
            ST_ISO_WAIT, ST_ISO_IDLE: part = 1'b1;
            default: begin
                tmr_run = 1'b0;
                part    = 1'b0;
            end
        endcase
        fwd_en = act && !part;
    end

    // R3: the limit-reaching collision partitions on the next cycle
    a_r3_limit_part: assert property (@(posedge clk) disable iff (rst)
        (!part && at_last && coll && state != ST_LINK_COLL) |=> part);

    // R4: a clean frame end leaves a zero count
    a_r4_clean_clear: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LINK_ACT && !act && !coll) |=> (count == '0));

    // R8: the count is frozen while isolated
    a_r8_hold_count: assert property (@(posedge clk) disable iff (rst)
        part |=> ($stable(count) || !part));

    // R9: leaving isolation always comes with a cleared count
    a_r9_reconnect_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(part) |-> (count == '0));

    // R6: entry into isolation only follows a collision
    a_r6_entry_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(part) |-> $past(coll));
endmodule

// File: rtl/port_partition_ctrl.sv
module port_partition_ctrl #(
    parameter int NUM_PORTS  = 4,
    parameter int COLL_LIMIT = 64,
    parameter int TW_LEN     = 500,
    localparam int CW        = $clog2(COLL_LIMIT + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bit_tick,
    input  logic [NUM_PORTS-1:0]    port_coll,
    input  logic [NUM_PORTS-1:0]    port_act,
    output logic [NUM_PORTS-1:0]    port_part,
    output logic [NUM_PORTS-1:0]    port_fwd_en,
    output logic [NUM_PORTS*CW-1:0] coll_count
);
    initial begin
        a_r6_window_range: assert (TW_LEN >= 450 && TW_LEN <= 560);
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        ppc_port_fsm #(.LIMIT(COLL_LIMIT), .TW_LEN(TW_LEN)) u_fsm (
            .clk(clk),
            .rst(rst),
            .bit_tick(bit_tick),
            .coll(port_coll[p]),
            .act(port_act[p]),
            .part(port_part[p]),
            .fwd_en(port_fwd_en[p]),
            .count(coll_count[p*CW +: CW])
        );

        // R8: an isolated port never forwards, even when active
        a_r8_no_forward: assert property (@(posedge clk) disable iff (rst)
            (port_part[p] && $past(port_part[p])) |-> !port_fwd_en[p]);
    end
endmodule

// File: tb/tb_port_partition_ctrl.sv
module tb_port_partition_ctrl;
    localparam int NP = 4;
    localparam int CW = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_tick = 1'b1;
    logic [NP-1:0] port_coll = '0;
    logic [NP-1:0] port_act = '0;
    logic [NP-1:0] port_part, port_fwd_en;
    logic [NP*CW-1:0] coll_count;

    int checks = 0;
    int failures = 0;

    port_partition_ctrl dut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick),
        .port_coll(port_coll), .port_act(port_act),
        .port_part(port_part), .port_fwd_en(port_fwd_en),
        .coll_count(coll_count)
    );

    always #4 clk = ~clk;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act_v, input int exp_v);
        checks++;
        if (act_v != exp_v) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
        end
    endtask

    function automatic int cnt(input int p);
        return int'(coll_count[p*CW +: CW]);
    endfunction

    task automatic coll_frame(input int p, input int len);
        port_act[p] = 1'b1; port_coll[p] = 1'b1;
        step(len);
        port_coll[p] = 1'b0;
        step(1);
        port_act[p] = 1'b0;
        step(1);
    endtask

    task automatic clean_frame(input int p, input int len);
        port_act[p] = 1'b1;
        step(len);
        port_act[p] = 1'b0;
        step(1);
    endtask

    task automatic t_reset;
        for (int p = 0; p < NP; p++) begin
            chk("R1 part after reset", int'(port_part[p]), 0);
            chk("R1 count after reset", cnt(p), 0);
        end
    endtask

    task automatic t_count_and_clear;
        coll_frame(0, 3);
        chk("R2 one collision", cnt(0), 1);
        coll_frame(0, 3);
        coll_frame(0, 5);
        chk("R5 collisions over frames accumulate", cnt(0), 3);
        port_act[0] = 1'b1; step(2);
        port_coll[0] = 1'b1; step(1); port_coll[0] = 1'b0; step(2);
        port_coll[0] = 1'b1; step(1);
        chk("R2 second collision inside one frame", cnt(0), 5);
        port_coll[0] = 1'b0; step(1); port_act[0] = 1'b0; step(1);
        chk("R5 frame with collision keeps count", cnt(0), 5);
        chk("R11 port 1 untouched", cnt(1), 0);
        clean_frame(0, 10);
        chk("R4 clean frame clears count", cnt(0), 0);
        chk("R7 short collisions keep port connected", int'(port_part[0]), 0);
    endtask

    task automatic t_limit_and_reconnect;
        for (int i = 0; i < 63; i++) coll_frame(0, 2);
        chk("R3 63 collisions count", cnt(0), 63);
        chk("R3 63 collisions not partitioned", int'(port_part[0]), 0);
        port_act[0] = 1'b1; port_coll[0] = 1'b1;
        step(1);
        chk("R3 64th collision partitions next cycle", int'(port_part[0]), 1);
        chk("R3 count reads limit", cnt(0), 64);
        port_coll[0] = 1'b0; step(1); port_act[0] = 1'b0; step(1);
        port_act[0] = 1'b1; step(2);
        chk("R8 no forward while partitioned", int'(port_fwd_en[0]), 0);
        port_coll[0] = 1'b1; step(3); port_coll[0] = 1'b0; step(1);
        port_act[0] = 1'b0; step(1);
        chk("R8 collision in partition keeps count", cnt(0), 64);
        chk("R11 port 1 still connected", int'(port_part[1]), 0);
        clean_frame(0, 100);
        chk("R9 short frame does not reconnect", int'(port_part[0]), 1);
        clean_frame(0, 600);
        chk("R9 long clean frame reconnects", int'(port_part[0]), 0);
        chk("R9 reconnect clears count", cnt(0), 0);
        port_act[0] = 1'b1; step(1);
        chk("R8 forward resumes after reconnect", int'(port_fwd_en[0]), 1);
        port_act[0] = 1'b0; step(1);
    endtask

    task automatic t_long_collision;
        port_act[1] = 1'b1; port_coll[1] = 1'b1;
        step(450);
        chk("R7 collision within window stays connected", int'(port_part[1]), 0);
        step(150);
        chk("R6 over-long collision partitions", int'(port_part[1]), 1);
        chk("R6 count unchanged by long collision", cnt(1), 1);
        chk("R11 port 0 unaffected", int'(port_part[0]), 0);
        port_coll[1] = 1'b0; port_act[1] = 1'b0; step(2);
        chk("R6 stays partitioned after collision ends", int'(port_part[1]), 1);
        clean_frame(1, 600);
        chk("R9 port 1 reconnects", int'(port_part[1]), 0);
    endtask

    task automatic t_tick_gate;
        bit_tick = 1'b0;
        port_act[2] = 1'b1; port_coll[2] = 1'b1;
        step(800);
        chk("R10 no ticks no partition", int'(port_part[2]), 0);
        bit_tick = 1'b1;
        step(600);
        chk("R10 ticks resume and partition", int'(port_part[2]), 1);
        port_coll[2] = 1'b0; port_act[2] = 1'b0; step(2);
        clean_frame(2, 600);
        chk("R9 port 2 reconnects", int'(port_part[2]), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_count_and_clear();
        t_limit_and_reconnect();
        t_long_collision();
        t_tick_gate();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule